// File: doc/BRIEF.md
# Wide Digest Modular Reducer

This block takes a 512-bit hash digest and returns its residue modulo one of two fixed primes: the Curve25519 field prime p = 2^255 - 19, or the prime order of the Ed25519 base-point subgroup, L = 2^252 + 27742317777372353535851937790883648493. A single select input picks the modulus for each run. The caller drives the digest and the select bit, and pulses start. Some cycles later, a one-cycle done pulse marks a valid 256-bit residue.

The reduction is sequential and handles one digest bit per clock, most significant bit first. On each step the running remainder is doubled and the next digest bit is appended. If the sum is at or above the modulus, the modulus is subtracted once. Because the remainder is always below the modulus, a single compare and subtract per step is enough.

The controller has three states:
- `IDLE` waits for start.
- `RUN` performs the 512 reduction steps.
- `FIN` raises done for one cycle.

The transitions are:
- IDLE→RUN when start is seen. This also captures the operands.
- RUN→RUN while bits remain.
- RUN→FIN after the last bit.
- FIN→IDLE unconditionally.

Top module: `hmr_reducer`

## Requirements
- R1: After reset, busy is 0, done is 0 and residue is 0.
- R2: When sel_order is 0 at start, residue equals the digest value modulo 2^255 - 19.
- R3: When sel_order is 1 at start, residue equals the digest value modulo L = 2^252 + 27742317777372353535851937790883648493.
- R4: The digest is an unsigned integer whose bits [7:0] form byte 0, the least significant byte. Bit 511 is the most significant bit.
- R5: Whenever done is high, residue is strictly below the modulus chosen at start, and its upper bits are zero.
- R6: done is high for exactly one cycle. It rises exactly DIG_W (512) clock cycles after the edge at which start was accepted.
- R7: sel_order and digest are sampled only at the accepting edge. Changing them during a run has no effect on the result.
- R8: A start pulse while busy is 1 is ignored. The run in progress keeps its result and its timing.
- R9: Between done and the next accepted start, residue holds its value, whatever happens on the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a reduction; accepted only when busy is 0 |
| sel_order | input | 1 | Modulus select: 0 selects 2^255-19, 1 selects L |
| digest | input | 512 | Little-endian digest value to reduce |
| busy | output | 1 | High from the accepting edge until done has been shown |
| done | output | 1 | One-cycle pulse: residue is valid |
| residue | output | 256 | Zero-extended remainder |

## Verification
Several properties are checked on every cycle. The checker confirms that done is a single-cycle pulse that lands exactly 512 cycles after acceptance, using its own latency counter. It confirms that every residue presented with done is below the modulus latched at start, and that residue is frozen while the block is idle.

Some behaviours can only be shown by the bench's scenarios:
- the numeric correctness of the residue for each modulus, including inputs equal to, just below and just above each prime;
- the byte ordering of the digest;
- immunity to operand changes and stray start pulses during a run.

// File: rtl/hmr_pkg.sv
package hmr_pkg;
    localparam int DIG_W_DEF = 512;
    localparam int RES_W_DEF = 256;

    // Curve field prime 2^255 - 19
    localparam logic [255:0] FIELD_PRIME =
        256'h7fffffff_ffffffff_ffffffff_ffffffff_ffffffff_ffffffff_ffffffff_ffffffed;
    // Base-point subgroup order 2^252 + 0x14def9dea2f79cd65812631a5cf5d3ed
    localparam logic [255:0] GROUP_ORDER =
        256'h10000000_00000000_00000000_00000000_14def9de_a2f79cd6_5812631a_5cf5d3ed;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } hmr_state_e;
endpackage

// File: rtl/hmr_step.sv
module hmr_step #(
    parameter int RES_W = 256
) (
    input  logic [RES_W-1:0] rem_in,
    input  logic             bit_in,
    input  logic [RES_W-1:0] modulus,
    output logic [RES_W-1:0] rem_out
);
    localparam int EXT_W = RES_W + 1;

    logic [EXT_W-1:0] doubled;
    logic [EXT_W-1:0] reduced;

    always_comb begin
        doubled = {rem_in, bit_in};
        reduced = doubled - {1'b0, modulus};
        if (doubled >= {1'b0, modulus}) begin
            rem_out = reduced[RES_W-1:0];
        end else begin
            rem_out = doubled[RES_W-1:0];
        end
    end
endmodule

// File: rtl/hmr_ctrl.sv
module hmr_ctrl
    import hmr_pkg::*;
#(
    parameter int DIG_W = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(DIG_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DIG_W - 1);

    hmr_state_e        state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (bit_cnt_q == LAST_BIT) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end else begin
                bit_cnt_q <= '0;
            end
        end
    end

    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b1;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_RUN:  step = 1'b1;
            ST_FIN:  done = 1'b1;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/hmr_reducer.sv
module hmr_reducer
    import hmr_pkg::*;
#(
    parameter int DIG_W = DIG_W_DEF,
    parameter int RES_W = RES_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sel_order,
    input  logic [DIG_W-1:0] digest,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] residue
);
    logic             load, step;
    logic [DIG_W-1:0] shift_q;
    logic [RES_W-1:0] rem_q, rem_next, mod_q;

    hmr_ctrl #(.DIG_W(DIG_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    hmr_step #(.RES_W(RES_W)) u_step (
        .rem_in  (rem_q),
        .bit_in  (shift_q[DIG_W-1]),
        .modulus (mod_q),
        .rem_out (rem_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            rem_q   <= '0;
            mod_q   <= FIELD_PRIME[RES_W-1:0];
        end else if (load) begin
            shift_q <= digest;
            rem_q   <= '0;
            mod_q   <= sel_order ? GROUP_ORDER[RES_W-1:0] : FIELD_PRIME[RES_W-1:0];
        end else if (step) begin
            shift_q <= {shift_q[DIG_W-2:0], 1'b0};
            rem_q   <= rem_next;
        end
    end

    assign residue = rem_q;
endmodule

// File: rtl/hmr_checker.sv
module hmr_checker
    import hmr_pkg::*;
#(
    parameter int DIG_W = DIG_W_DEF,
    parameter int RES_W = RES_W_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             sel_order,
    input logic             busy,
    input logic             done,
    input logic [RES_W-1:0] residue
);
    localparam int LAT_W = $clog2(DIG_W) + 2;

    logic             sel_seen;
    logic [LAT_W-1:0] lat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_seen <= 1'b0;
            lat_cnt  <= '0;
        end else if (start && !busy) begin
            sel_seen <= sel_order;
            lat_cnt  <= '0;
        end else if (busy) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == LAT_W'(DIG_W)));

    assert_idle_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (residue < (sel_seen ? GROUP_ORDER[RES_W-1:0] : FIELD_PRIME[RES_W-1:0])));

    assert_residue_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(residue));
endmodule

bind hmr_reducer hmr_checker #(.DIG_W(DIG_W), .RES_W(RES_W)) u_hmr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sel_order (sel_order),
    .busy      (busy),
    .done      (done),
    .residue   (residue)
);

// File: tb/tb_hmr_reducer.sv
module tb_hmr_reducer;
    localparam int DW = 512;
    localparam int RW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          sel_order = 1'b0;
    logic [DW-1:0] digest = '0;
    logic          busy, done;
    logic [RW-1:0] residue;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    hmr_reducer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sel_order(sel_order),
        .digest(digest), .busy(busy), .done(done), .residue(residue)
    );

    logic [DW-1:0] mod_p, mod_l;
    logic [63:0]   rng = 64'h9e3779b97f4a7c15;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    // disturb: alter operands and pulse start mid-run (R7, R8)
    task automatic run_case(input logic [DW-1:0] d, input logic s, input bit disturb, input string req);
        logic [DW-1:0] expv;
        int n = 0;
        expv = d % (s ? mod_l : mod_p);
        @(negedge clk);
        digest = d; sel_order = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            digest = ~d; sel_order = ~s;
        end
        while (!done && n < 2000) begin
            if (disturb && n == 100) start = 1'b1;
            if (disturb && n == 101) start = 1'b0;
            @(negedge clk);
            n++;
        end
        chk(n == DW, "R6 latency", DW'(n), DW'(DW));
        chk({256'b0, residue} == expv, req, {256'b0, residue}, expv);
        chk(residue < (s ? mod_l[RW-1:0] : mod_p[RW-1:0]), "R5 range", {256'b0, residue}, expv);
        @(negedge clk);
        chk(!done && !busy, "R6 single pulse", {510'b0, done, busy}, '0);
    endtask

    initial begin
        mod_p = (DW'(1) << 255) - DW'(19);
        mod_l = (DW'(1) << 252) + DW'(128'h14def9dea2f79cd65812631a5cf5d3ed);

        repeat (3) @(negedge clk);
        chk(!busy && !done && residue == '0, "R1 reset", {254'b0, busy, done, residue}, '0);
        rst_n = 1'b1;

        // R2 field prime corners
        run_case('0, 1'b0, 1'b0, "R2 zero");
        run_case(DW'(1), 1'b0, 1'b0, "R2 one");
        run_case(mod_p, 1'b0, 1'b0, "R2 p itself");
        run_case(mod_p - 1, 1'b0, 1'b0, "R2 p-1");
        run_case(DW'(1) << 255, 1'b0, 1'b0, "R2 2^255 gives 19");
        run_case({DW{1'b1}}, 1'b0, 1'b0, "R2 all ones");
        // R3 group order corners
        run_case(mod_l, 1'b1, 1'b0, "R3 L itself");
        run_case(mod_l + 5, 1'b1, 1'b0, "R3 L+5");
        run_case(mod_l - 1, 1'b1, 1'b0, "R3 L-1");
        run_case({DW{1'b1}}, 1'b1, 1'b0, "R3 all ones");
        // R4 byte order: byte 0 is least significant, bit 511 is MSB
        run_case(DW'(8'hab), 1'b1, 1'b0, "R4 byte0 value");
        run_case(DW'(1) << 511, 1'b0, 1'b0, "R4 msb p");
        run_case(DW'(1) << 511, 1'b1, 1'b0, "R4 msb L");
        // sweep of pseudo-random digests on both moduli
        for (int k = 0; k < 24; k++) begin
            logic [DW-1:0] d;
            for (int w = 0; w < DW / 64; w++) begin
                rng = next_rand(rng);
                d[w*64 +: 64] = rng;
            end
            run_case(d, k[0], 1'b0, k[0] ? "R3 sweep" : "R2 sweep");
        end
        // R7 / R8: operands changed and start pulsed during the run
        run_case({16{32'hdeadbeef}}, 1'b0, 1'b1, "R7 R8 disturbed p");
        run_case({16{32'h01234567}}, 1'b1, 1'b1, "R7 R8 disturbed L");
        // R9: residue holds while idle despite input activity
        begin
            logic [RW-1:0] held;
            held = residue;
            digest = '1; sel_order = 1'b0;
            repeat (20) @(negedge clk);
            chk(residue == held && !busy, "R9 hold", {256'b0, residue}, {256'b0, held});
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule